// File: doc/BRIEF.md
# USB IN-Endpoint Packet Transmit Sequencer

This block sequences the transmit side of one USB device IN endpoint. Software arms the endpoint through a command write carrying four fields (enable, last-byte-queued, data toggle, isochronous select). Link-side events (IN token, host ACK, start of frame, the low bit of the current frame number) and the state of the payload FIFO decide when a packet leaves, which data PID leads it, and how it ends. The block emits one symbol per clock towards the serialiser: a PID byte, payload bytes popped from the FIFO, a CRC16-append marker, a forced bit-stuff error, an EOP, or a STALL or NAK handshake.

Status bits report transaction completion, host acknowledgement and FIFO underrun. A status read pulse clears the acknowledge and underrun bits. Isochronous packets can be queued ahead for a frame of chosen parity; a queued packet that no IN token collects within its frame is discarded at the next SOF. Bit stuffing, NRZI, CRC arithmetic, token decoding and the FIFO memory live outside this block.

Top module: `usb_in_tx_seq`

## Requirements
- R1: An IN token starts a packet only while the enable bit is set; hardware clears enable in the EOP cycle of every packet and in the cycle a STALL is answered.
- R2: In non-isochronous mode the PID byte is 8'hC3 (DATA0) when toggle is 0 and 8'h4B (DATA1) when toggle is 1; hardware never alters toggle.
- R3: In isochronous mode an IN token is accepted only when frame_lsb equals toggle; otherwise no symbol is emitted. A non-isochronous IN token that finds enable clear is answered with a NAK symbol (kind 7, byte 8'h5A).
- R4: In isochronous mode the PID byte is always 8'hC3 regardless of toggle.
- R5: When the FIFO is empty during the body and the last flag is clear, the block emits a stuff-error symbol (kind 5) followed by EOP (kind 4), sets the underrun bit and done, leaves acknowledge clear and keeps the last flag unchanged.
- R6: A packet is emitted one symbol per cycle as PID (kind 1), each FIFO byte as DATA (kind 2) with a pop, CRC marker (kind 3), then EOP; with the last flag set and an empty FIFO this gives a zero-length packet, and the last flag is cleared at EOP.
- R7: In non-isochronous mode, an ACK arriving after EOP sets both done and acknowledge.
- R8: If no ACK arrives within ACK_TIMEOUT cycles after EOP, done is set and acknowledge stays clear, not earlier.
- R9: An isochronous packet sets done and acknowledge at its EOP.
- R10: In isochronous mode, an SOF arriving while enable is set and frame_lsb equals toggle, with no IN token, pulses the FIFO flush, sets done, clears enable and last, and leaves acknowledge clear; an SOF without that match does nothing.
- R11: A status read clears acknowledge and underrun but not done; a command write with enable set clears done and acknowledge.
- R12: An IN token while ep_halt is high emits a STALL symbol (kind 6, byte 8'h1E) and sends no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_en | input | 1 | Transmit enable field |
| cmd_last | input | 1 | Last byte queued field |
| cmd_toggle | input | 1 | Data toggle / frame parity field |
| cmd_iso | input | 1 | Isochronous mode field |
| stat_rd | input | 1 | Status read strobe |
| in_token | input | 1 | IN token received for this endpoint |
| ack_rx | input | 1 | Host ACK handshake received |
| ep_halt | input | 1 | Endpoint halted, answer with STALL |
| sof | input | 1 | Start of frame seen |
| frame_lsb | input | 1 | Bit 0 of the current frame number |
| fifo_empty | input | 1 | Payload FIFO empty |
| fifo_rdata | input | 8 | Payload FIFO head byte |
| fifo_pop | output | 1 | Pop the FIFO head |
| fifo_flush | output | 1 | Discard FIFO contents |
| sym_valid | output | 1 | A symbol is emitted this cycle |
| sym_kind | output | 3 | Symbol kind: 1 PID, 2 DATA, 3 CRC, 4 EOP, 5 stuff error, 6 STALL, 7 NAK |
| sym_data | output | 8 | Byte for PID, DATA, STALL and NAK symbols, else zero |
| tx_en_o | output | 1 | Transmit enable bit |
| last_o | output | 1 | Last byte queued bit |
| toggle_o | output | 1 | Toggle bit |
| iso_o | output | 1 | Isochronous mode bit |
| done_o | output | 1 | Transaction done status |
| ack_o | output | 1 | Acknowledge status |
| urun_o | output | 1 | Underrun status |

## Verification
The bench builds the block with ACK_TIMEOUT set to 6 and ISO_EN set to 1. The short timeout lets the bench sample done one cycle before and one cycle after the expiry window in a few dozen cycles, and the isochronous option brings the frame-parity gating, the forced DATA0 PID and the SOF discard within reach alongside the handshake-driven path.

// File: rtl/usbtx_pkg.sv
`timescale 1ns/1ps
package usbtx_pkg;

   typedef enum logic [2:0] {
      SYM_NONE  = 3'd0,
      SYM_PID   = 3'd1,
      SYM_DATA  = 3'd2,
      SYM_CRC   = 3'd3,
      SYM_EOP   = 3'd4,
      SYM_ERR   = 3'd5,
      SYM_STALL = 3'd6,
      SYM_NAK   = 3'd7
   } sym_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PID,
      ST_BODY,
      ST_EOP,
      ST_WAIT
   } seq_st_e;

   localparam logic [3:0] PID_DATA0 = 4'h3;
   localparam logic [3:0] PID_DATA1 = 4'hB;
   localparam logic [3:0] PID_NAK   = 4'hA;
   localparam logic [3:0] PID_STALL = 4'hE;

   // PID byte on the wire: check nibble is the complement of the code
   function automatic logic [7:0] pid_byte(input logic [3:0] code);
      return {~code, code};
   endfunction

endpackage

// File: rtl/usbtx_cmd.sv
`timescale 1ns/1ps
module usbtx_cmd #(
   parameter bit ISO_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic cmd_en,
   input  logic cmd_last,
   input  logic cmd_toggle,
   input  logic cmd_iso,
   input  logic clr_en,
   input  logic clr_last,
   output logic en_q,
   output logic last_q,
   output logic toggle_q,
   output logic iso_q,
   output logic arm
);

   assign arm = cmd_wr && cmd_en;

   // hardware clear has priority over a software write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         last_q   <= 1'b0;
         toggle_q <= 1'b0;
      end else begin
         if (clr_en)
            en_q <= 1'b0;
         else if (cmd_wr)
            en_q <= cmd_en;
         if (clr_last)
            last_q <= 1'b0;
         else if (cmd_wr)
            last_q <= cmd_last;
         if (cmd_wr)
            toggle_q <= cmd_toggle;
      end
   end

   if (ISO_EN) begin : g_iso
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            iso_q <= 1'b0;
         else if (cmd_wr)
            iso_q <= cmd_iso;
      end
   end else begin : g_no_iso
      assign iso_q = 1'b0;
   end

   // R2
   toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(toggle_q));

endmodule

// File: rtl/usbtx_stat.sv
`timescale 1ns/1ps
module usbtx_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_rd,
   input  logic arm,
   input  logic ev_done,
   input  logic ev_ack,
   input  logic ev_urun,
   output logic done_q,
   output logic ack_q,
   output logic urun_q
);

   // a hardware event in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ack_q  <= 1'b0;
         urun_q <= 1'b0;
      end else begin
         if (ev_done)
            done_q <= 1'b1;
         else if (arm)
            done_q <= 1'b0;
         if (ev_ack)
            ack_q <= 1'b1;
         else if (arm || stat_rd)
            ack_q <= 1'b0;
         if (ev_urun)
            urun_q <= 1'b1;
         else if (stat_rd)
            urun_q <= 1'b0;
      end
   end

   // R7
   ack_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> done_q);

   // R11
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ev_urun) |=> !urun_q);

endmodule

// File: rtl/usbtx_fsm.sv
`timescale 1ns/1ps
module usbtx_fsm
   import usbtx_pkg::*;
#(
   parameter int ACK_TIMEOUT = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_token,
   input  logic       ack_rx,
   input  logic       sof,
   input  logic       frame_lsb,
   input  logic       ep_halt,
   input  logic       fifo_empty,
   input  logic [7:0] fifo_rdata,
   input  logic       en,
   input  logic       last,
   input  logic       toggle,
   input  logic       iso,
   output sym_e       sym_kind,
   output logic [7:0] sym_data,
   output logic       fifo_pop,
   output logic       fifo_flush,
   output logic       clr_en,
   output logic       clr_last,
   output logic       ev_done,
   output logic       ev_ack,
   output logic       ev_urun
);

   localparam int CNT_W = (ACK_TIMEOUT > 2) ? $clog2(ACK_TIMEOUT) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACK_TIMEOUT - 1);

   seq_st_e          st, st_n;
   logic             err_q, err_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             frame_ok;

   // isochronous packets are bound to frames of one parity
   assign frame_ok = !iso || (frame_lsb == toggle);

   always_comb begin
      st_n       = st;
      err_n      = err_q;
      cnt_n      = cnt;
      sym_kind   = SYM_NONE;
      sym_data   = 8'h00;
      fifo_pop   = 1'b0;
      fifo_flush = 1'b0;
      clr_en     = 1'b0;
      clr_last   = 1'b0;
      ev_done    = 1'b0;
      ev_ack     = 1'b0;
      ev_urun    = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (in_token) begin
               if (ep_halt) begin
                  sym_kind = SYM_STALL;
                  sym_data = pid_byte(PID_STALL);
                  clr_en   = 1'b1;
               end else if (en && frame_ok) begin
                  st_n  = ST_PID;
                  err_n = 1'b0;
               end else if (!iso) begin
                  sym_kind = SYM_NAK;
                  sym_data = pid_byte(PID_NAK);
               end
            end else if (sof && iso && en && frame_ok) begin
               fifo_flush = 1'b1;
               clr_en     = 1'b1;
               clr_last   = 1'b1;
               ev_done    = 1'b1;
            end
         end
         ST_PID: begin
            sym_kind = SYM_PID;
            sym_data = pid_byte((toggle && !iso) ? PID_DATA1 : PID_DATA0);
            st_n     = ST_BODY;
         end
         ST_BODY: begin
            if (!fifo_empty) begin
               sym_kind = SYM_DATA;
               sym_data = fifo_rdata;
               fifo_pop = 1'b1;
            end else if (last) begin
               sym_kind = SYM_CRC;
               st_n     = ST_EOP;
               err_n    = 1'b0;
            end else begin
               sym_kind = SYM_ERR;
               ev_urun  = 1'b1;
               st_n     = ST_EOP;
               err_n    = 1'b1;
            end
         end
         ST_EOP: begin
            sym_kind = SYM_EOP;
            clr_en   = 1'b1;
            clr_last = !err_q;
            if (err_q || iso) begin
               ev_done = 1'b1;
               ev_ack  = !err_q;
               st_n    = ST_IDLE;
            end else begin
               st_n  = ST_WAIT;
               cnt_n = '0;
            end
         end
         ST_WAIT: begin
            if (ack_rx) begin
               ev_done = 1'b1;
               ev_ack  = 1'b1;
               st_n    = ST_IDLE;
            end else if (cnt == LAST_CNT) begin
               ev_done = 1'b1;
               st_n    = ST_IDLE;
            end else begin
               cnt_n = cnt + 1'b1;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         err_q <= 1'b0;
         cnt   <= '0;
      end else begin
         st    <= st_n;
         err_q <= err_n;
         cnt   <= cnt_n;
      end
   end

   // R5
   err_then_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_kind == SYM_ERR) |=> (sym_kind == SYM_EOP));

   // R6
   crc_then_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_kind == SYM_CRC) |=> (sym_kind == SYM_EOP));

   // R4
   iso_data0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_kind == SYM_PID && iso) |-> (sym_data == 8'hC3));

   // R8
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> (cnt <= LAST_CNT));

endmodule

// File: rtl/usb_in_tx_seq.sv
`timescale 1ns/1ps
module usb_in_tx_seq
   import usbtx_pkg::*;
#(
   parameter int ACK_TIMEOUT = 64,
   parameter bit ISO_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic       cmd_en,
   input  logic       cmd_last,
   input  logic       cmd_toggle,
   input  logic       cmd_iso,
   input  logic       stat_rd,
   input  logic       in_token,
   input  logic       ack_rx,
   input  logic       ep_halt,
   input  logic       sof,
   input  logic       frame_lsb,
   input  logic       fifo_empty,
   input  logic [7:0] fifo_rdata,
   output logic       fifo_pop,
   output logic       fifo_flush,
   output logic       sym_valid,
   output logic [2:0] sym_kind,
   output logic [7:0] sym_data,
   output logic       tx_en_o,
   output logic       last_o,
   output logic       toggle_o,
   output logic       iso_o,
   output logic       done_o,
   output logic       ack_o,
   output logic       urun_o
);

   if (ACK_TIMEOUT < 2) begin : g_bad_timeout
      $error("usb_in_tx_seq: ACK_TIMEOUT must be at least 2");
   end

   sym_e kind;
   logic clr_en, clr_last, ev_done, ev_ack, ev_urun, arm;

   usbtx_cmd #(.ISO_EN(ISO_EN)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_en     (cmd_en),
      .cmd_last   (cmd_last),
      .cmd_toggle (cmd_toggle),
      .cmd_iso    (cmd_iso),
      .clr_en     (clr_en),
      .clr_last   (clr_last),
      .en_q       (tx_en_o),
      .last_q     (last_o),
      .toggle_q   (toggle_o),
      .iso_q      (iso_o),
      .arm        (arm)
   );

   usbtx_fsm #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_token   (in_token),
      .ack_rx     (ack_rx),
      .sof        (sof),
      .frame_lsb  (frame_lsb),
      .ep_halt    (ep_halt),
      .fifo_empty (fifo_empty),
      .fifo_rdata (fifo_rdata),
      .en         (tx_en_o),
      .last       (last_o),
      .toggle     (toggle_o),
      .iso        (iso_o),
      .sym_kind   (kind),
      .sym_data   (sym_data),
      .fifo_pop   (fifo_pop),
      .fifo_flush (fifo_flush),
      .clr_en     (clr_en),
      .clr_last   (clr_last),
      .ev_done    (ev_done),
      .ev_ack     (ev_ack),
      .ev_urun    (ev_urun)
   );

   usbtx_stat u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_rd (stat_rd),
      .arm     (arm),
      .ev_done (ev_done),
      .ev_ack  (ev_ack),
      .ev_urun (ev_urun),
      .done_q  (done_o),
      .ack_q   (ack_o),
      .urun_q  (urun_o)
   );

   assign sym_kind  = kind;
   assign sym_valid = (kind != SYM_NONE);

   // R1
   eop_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SYM_EOP && !cmd_wr) |=> !tx_en_o);

   // R12
   stall_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SYM_STALL && !cmd_wr) |=> !tx_en_o);

   // R5
   urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SYM_ERR) |=> urun_o);

   // R6
   pop_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (kind == SYM_DATA && !fifo_empty));

endmodule

// File: tb/usb_in_tx_seq_test.sv
`timescale 1ns/1ps
module usb_in_tx_seq_test;

   localparam int TO = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 0, cmd_en = 0, cmd_last = 0, cmd_toggle = 0, cmd_iso = 0;
   logic stat_rd = 0, in_token = 0, ack_rx = 0, ep_halt = 0, sof = 0, frame_lsb = 0;
   logic fifo_empty;
   logic [7:0] fifo_rdata;
   logic fifo_pop, fifo_flush, sym_valid;
   logic [2:0] sym_kind;
   logic [7:0] sym_data;
   logic tx_en_o, last_o, toggle_o, iso_o, done_o, ack_o, urun_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   usb_in_tx_seq #(.ACK_TIMEOUT(TO), .ISO_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_en(cmd_en),
      .cmd_last(cmd_last), .cmd_toggle(cmd_toggle), .cmd_iso(cmd_iso),
      .stat_rd(stat_rd), .in_token(in_token), .ack_rx(ack_rx),
      .ep_halt(ep_halt), .sof(sof), .frame_lsb(frame_lsb),
      .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
      .fifo_pop(fifo_pop), .fifo_flush(fifo_flush), .sym_valid(sym_valid),
      .sym_kind(sym_kind), .sym_data(sym_data), .tx_en_o(tx_en_o),
      .last_o(last_o), .toggle_o(toggle_o), .iso_o(iso_o),
      .done_o(done_o), .ack_o(ack_o), .urun_o(urun_o)
   );

   // host-side FIFO model
   logic [7:0] mem [16];
   logic [3:0] rdp;
   logic [3:0] wrp = 4'd0;
   assign fifo_empty = (rdp == wrp);
   assign fifo_rdata = mem[rdp];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rdp <= 4'd0;
      else if (fifo_flush) rdp <= wrp;
      else if (fifo_pop)   rdp <= rdp + 4'd1;
   end

   // symbol monitor, samples mid-low-phase
   int nlog = 0;
   int nflush = 0;
   logic [2:0] lk [32];
   logic [7:0] ld [32];
   always begin
      @(negedge clk);
      #1;
      if (sym_valid && nlog < 32) begin
         lk[nlog] = sym_kind;
         ld[nlog] = sym_data;
         nlog++;
      end
      if (fifo_flush) nflush++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_sym(input string req, input int idx, input int kind, input int data);
      chk(req, (nlog > idx) ? int'(lk[idx]) : -1, kind);
      if (data >= 0) chk(req, (nlog > idx) ? int'(ld[idx]) : -1, data);
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      mem[wrp] = b;
      wrp = wrp + 4'd1;
   endtask

   task automatic wr_cmd(input logic en, input logic last, input logic tog, input logic iso);
      tick();
      cmd_wr = 1; cmd_en = en; cmd_last = last; cmd_toggle = tog; cmd_iso = iso;
      tick();
      cmd_wr = 0;
   endtask

   task automatic pulse_token();
      tick(); in_token = 1;
      tick(); in_token = 0;
   endtask

   task automatic read_status();
      tick(); stat_rd = 1;
      tick(); stat_rd = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset en", tx_en_o, 0);
      chk("R6 reset last", last_o, 0);
      chk("R11 reset done", done_o, 0);
      chk("R7 reset ack", ack_o, 0);
      chk("R5 reset urun", urun_o, 0);
      chk("R6 reset idle", sym_valid, 0);
   endtask

   task automatic t_data0_ack();
      push(8'hA1); push(8'hB2);
      wr_cmd(1, 1, 0, 0);
      nlog = 0;
      pulse_token();
      tick(5);
      chk_sym("R2 DATA0 pid", 0, 1, 8'hC3);
      chk_sym("R6 byte0", 1, 2, 8'hA1);
      chk_sym("R6 byte1", 2, 2, 8'hB2);
      chk_sym("R6 crc", 3, 3, -1);
      chk_sym("R6 eop", 4, 4, -1);
      chk("R1 en cleared", tx_en_o, 0);
      chk("R6 last cleared", last_o, 0);
      chk("R7 done waits for ack", done_o, 0);
      ack_rx = 1;
      tick();
      ack_rx = 0;
      chk("R7 done", done_o, 1);
      chk("R7 ack", ack_o, 1);
      read_status();
      chk("R11 read clears ack", ack_o, 0);
      chk("R11 read keeps done", done_o, 1);
   endtask

   task automatic t_data1_timeout();
      push(8'h55);
      wr_cmd(1, 1, 1, 0);
      chk("R11 arm clears done", done_o, 0);
      nlog = 0;
      pulse_token();
      tick(9);
      chk_sym("R2 DATA1 pid", 0, 1, 8'h4B);
      chk_sym("R6 byte", 1, 2, 8'h55);
      chk_sym("R6 crc", 2, 3, -1);
      chk_sym("R6 eop", 3, 4, -1);
      chk("R8 not early", done_o, 0);
      tick();
      chk("R8 done on timeout", done_o, 1);
      chk("R8 ack clear", ack_o, 0);
      chk("R2 toggle kept", toggle_o, 1);
   endtask

   task automatic t_zlp();
      wr_cmd(1, 1, 0, 0);
      nlog = 0;
      pulse_token();
      tick(3);
      chk_sym("R6 zlp pid", 0, 1, 8'hC3);
      chk_sym("R6 zlp crc", 1, 3, -1);
      chk_sym("R6 zlp eop", 2, 4, -1);
      chk("R6 zlp length", nlog, 3);
      ack_rx = 1;
      tick();
      ack_rx = 0;
      chk("R7 zlp ack", ack_o, 1);
   endtask

   task automatic t_underrun();
      push(8'h11);
      wr_cmd(1, 0, 0, 0);
      nlog = 0;
      pulse_token();
      tick(4);
      chk_sym("R5 pid", 0, 1, 8'hC3);
      chk_sym("R5 byte", 1, 2, 8'h11);
      chk_sym("R5 stuff err", 2, 5, -1);
      chk_sym("R5 eop", 3, 4, -1);
      chk("R5 urun", urun_o, 1);
      chk("R5 done", done_o, 1);
      chk("R5 ack", ack_o, 0);
      chk("R1 en cleared", tx_en_o, 0);
      read_status();
      chk("R11 read clears urun", urun_o, 0);
   endtask

   task automatic t_nak();
      nlog = 0;
      pulse_token();
      tick(3);
      chk("R3 nak count", nlog, 1);
      chk_sym("R3 nak", 0, 7, 8'h5A);
   endtask

   task automatic t_stall();
      wr_cmd(1, 1, 0, 0);
      ep_halt = 1;
      nlog = 0;
      pulse_token();
      tick(2);
      ep_halt = 0;
      chk("R12 stall count", nlog, 1);
      chk_sym("R12 stall", 0, 6, 8'h1E);
      chk("R1 stall clears en", tx_en_o, 0);
   endtask

   task automatic t_iso_match();
      push(8'h77);
      frame_lsb = 1;
      wr_cmd(1, 1, 1, 1);
      nlog = 0;
      pulse_token();
      tick(4);
      chk_sym("R4 iso DATA0", 0, 1, 8'hC3);
      chk_sym("R6 iso byte", 1, 2, 8'h77);
      chk_sym("R6 iso crc", 2, 3, -1);
      chk_sym("R6 iso eop", 3, 4, -1);
      chk("R9 iso done", done_o, 1);
      chk("R9 iso ack", ack_o, 1);
   endtask

   task automatic t_iso_flush();
      push(8'h88);
      frame_lsb = 0;
      wr_cmd(1, 1, 1, 1);
      chk("R11 arm clears ack", ack_o, 0);
      nlog = 0;
      nflush = 0;
      pulse_token();
      tick(3);
      chk("R3 iso mismatch silent", nlog, 0);
      chk("R3 iso mismatch keeps en", tx_en_o, 1);
      tick(); sof = 1;
      tick(); sof = 0;
      chk("R10 sof mismatch no flush", nflush, 0);
      chk("R10 sof mismatch keeps en", tx_en_o, 1);
      frame_lsb = 1;
      tick(); sof = 1;
      tick(); sof = 0;
      chk("R10 flush pulse", nflush, 1);
      chk("R10 done", done_o, 1);
      chk("R10 ack clear", ack_o, 0);
      chk("R10 en cleared", tx_en_o, 0);
      chk("R10 last cleared", last_o, 0);
      chk("R10 fifo emptied", fifo_empty, 1);
      chk("R10 no symbols", nlog, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual expired expected finished");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick();
      t_reset();
      t_data0_ack();
      t_data1_timeout();
      t_zlp();
      t_underrun();
      t_nak();
      t_stall();
      t_iso_match();
      t_iso_flush();
      tick(2);
      finish_run();
   end

endmodule